// File: doc/BRIEF.md
# Byte-Lane Parity Error Capture Register

This block sits next to a 32-bit memory data path whose storage keeps one parity bit for every byte lane. On each memory write it produces the four lane parity bits that the array stores beside the data. On each memory read it checks the returned data against the returned parity bits.

The first failing read is recorded in two places. The failing lanes are marked in a byte-wide control/status register, and the access address is held in a 32-bit error-address register. An interrupt request is raised while an error is pending and interrupts are enabled. The request is meant to be wired to interrupt priority level 7.

Software reads both registers through a simple single-cycle register port. Any write to the status register clears the record. A test control makes every write store the wrong parity, so that the checker can be exercised through the normal read path.

Top module: `parity_err_capture`

## Requirements
- R1: Parity is odd per byte lane. With the test bit clear, `mem_wr_par[i]` is 1 exactly when data bits `8i+7..8i` of `mem_wr_data` hold an even number of ones. Lane i covers bits 8i+7..8i, so lane 3 is bits 31..24 and lane 0 is bits 7..0.
- R2: While status bit 5 (test) is set, every lane of `mem_wr_par` is the inverse of the R1 value.
- R3: A read with `mem_rd_en` high and status bit 4 (check enable) set fails in lane i when that lane's eight data bits plus `mem_rd_par[i]` hold an even number of ones. The cycle after such a read, status bit i is set for every failing lane, bit 7 (pending) is set, and the error-address register holds `mem_rd_addr`.
- R4: While status bit 4 is clear, no error is recorded, whatever the read parity.
- R5: Once pending is set, later failing reads change neither the lane flags nor the error address.
- R6: A register write at offset 0 loads status bits 6..4 from `reg_wdata[6:4]`. In the same edge it clears pending, the lane flags and the error address. `reg_wdata` bits 7 and 3..0 have no effect.
- R7: `irq` is high exactly when pending and status bit 6 (interrupt enable) are both set. It falls in the cycle after a clearing write.
- R8: After a synchronous active-low reset, the status register, the error address and `irq` are all zero.
- R9: Register reads are combinational. Offset 0 returns the status byte in `reg_rdata[7:0]`, offset 4 returns the error address, and offsets 1..3 and 5..7 return zero. Writes at any offset other than 0 have no effect.
- R10: When a status-register write and a failing read happen in the same cycle, the write wins and the error is not recorded.
- R11: A bad parity on the read bus while `mem_rd_en` is low is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_wr_en | input | 1 | Memory write strobe (informational, parity is combinational) |
| mem_wr_data | input | 32 | Data being written to memory |
| mem_wr_par | output | 4 | Lane parity bits to store with the write |
| mem_rd_en | input | 1 | Memory read data valid |
| mem_rd_addr | input | 32 | Address of the read access |
| mem_rd_data | input | 32 | Data returned by the memory |
| mem_rd_par | input | 4 | Parity bits returned by the memory |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request (level 7) |

## Verification
The assertions assume that reset is held for at least one clock edge before any access, and that every input is stable around the rising edge. They also assume that `mem_rd_par` comes from the same parity store that `mem_wr_par` filled. The bench drives all inputs at the falling edge and keeps a sideband parity array in which each written word's parity is stored. It corrupts that array only through explicit flip masks, so every recorded error comes from a known lane pattern.

// File: rtl/pec_pkg.sv
// Package: shared layout of the status register for the parity capture block.
// Assumes an 8-bit status register with four lane flags in its low nibble.
package pec_pkg;
    localparam int CSR_W      = 8;
    localparam int NUM_FLAGS  = 4;
    localparam int BIT_PEND   = 7;
    localparam int BIT_IEN    = 6;
    localparam int BIT_TEST   = 5;
    localparam int BIT_CHK    = 4;

    // Status register image, most significant bit first.
    typedef struct packed {
        logic                 pend;
        logic                 ien;
        logic                 test;
        logic                 chk;
        logic [NUM_FLAGS-1:0] lanes;
    } csr_t;
endpackage

// File: rtl/pec_par_gen.sv
// Module: per-lane odd parity generator for the write path.
// Each output bit makes its lane plus parity hold an odd number of ones.
// When invert is high, every lane bit is flipped (deliberate bad parity).
// Assumes DATA_W is a whole multiple of LANE_W.
module pec_par_gen #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic              invert,
    output logic [LANES-1:0]  par
);
    // One odd-parity bit per lane, optionally inverted.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb par[g] = ~(^data[g*LANE_W +: LANE_W]) ^ invert;
    end
endmodule

// File: rtl/pec_par_check.sv
// Module: per-lane odd parity checker for the read path.
// A lane fails when its data bits and its parity bit hold an even number of ones.
// The fail mask is forced to zero when enable is low.
// Assumes DATA_W is a whole multiple of LANE_W.
module pec_par_check #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  par,
    input  logic              enable,
    output logic [LANES-1:0]  fail
);
    // Even total count in a lane means that lane is in error.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb fail[g] = enable & ~(^{data[g*LANE_W +: LANE_W], par[g]});
    end
endmodule

// File: rtl/pec_regs.sv
// Module: status and error-address registers with a register read mux.
// It captures the first error record and holds it until software writes offset 0.
// A write at offset 0 has priority over an error captured in the same cycle.
// Assumes the fail mask is already gated by the check enable and the read strobe.
module pec_regs #(
    parameter int ADDR_W   = 32,
    parameter int REG_AW   = 3,
    parameter int RDATA_W  = 32,
    parameter int ADDR_OFF = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [pec_pkg::NUM_FLAGS-1:0] fail,
    input  logic [ADDR_W-1:0]             fail_addr,
    input  logic                          reg_wr_en,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [RDATA_W-1:0]            reg_wdata,
    output pec_pkg::csr_t                 csr_q,
    output logic [ADDR_W-1:0]             err_addr_q,
    output logic [RDATA_W-1:0]            reg_rdata
);
    import pec_pkg::*;

    localparam logic [REG_AW-1:0] OFF_CSR  = '0;
    localparam logic [REG_AW-1:0] OFF_ADDR = REG_AW'(ADDR_OFF);

    logic wr_csr;
    logic capture;
    logic unused_wdata;

    // Decode a status-register write.
    always_comb wr_csr = reg_wr_en && (reg_addr == OFF_CSR);

    // Record only the first error, and never in a cycle with a clearing write.
    always_comb capture = (|fail) && !csr_q.pend && !wr_csr;

    // Bits of the write data that the status register does not use.
    always_comb unused_wdata = ^{reg_wdata[RDATA_W-1:BIT_IEN+1], reg_wdata[BIT_CHK-1:0]};

    // Update the control bits, the pending flag and the lane flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else if (wr_csr) begin
            csr_q.pend  <= 1'b0;
            csr_q.ien   <= reg_wdata[BIT_IEN];
            csr_q.test  <= reg_wdata[BIT_TEST];
            csr_q.chk   <= reg_wdata[BIT_CHK];
            csr_q.lanes <= '0;
        end else if (capture) begin
            csr_q.pend  <= 1'b1;
            csr_q.lanes <= fail;
        end
    end

    // Latch the failing address, or clear it on a status write.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_csr) begin
            err_addr_q <= '0;
        end else if (capture) begin
            err_addr_q <= fail_addr;
        end
    end

    // Combinational register read mux; unmapped offsets read as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_CSR) begin
            reg_rdata[CSR_W-1:0] = csr_q;
        end else if (reg_addr == OFF_ADDR) begin
            reg_rdata = RDATA_W'(err_addr_q);
        end
    end
endmodule

// File: rtl/parity_err_capture.sv
// Module: top of the byte-lane parity error capture block.
// It generates write parity, checks read parity, captures the first error and
// raises irq while an error is pending and interrupts are enabled.
// Assumes a 32-bit data path with four byte lanes, matching the status layout.
module parity_err_capture #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 32,
    parameter int REG_AW = 3,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_wr_en,
    input  logic [DATA_W-1:0] mem_wr_data,
    output logic [LANES-1:0]  mem_wr_par,
    input  logic              mem_rd_en,
    input  logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic [LANES-1:0]  mem_rd_par,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    import pec_pkg::*;

    csr_t               csr_q;
    logic [ADDR_W-1:0]  err_addr_q;
    logic [LANES-1:0]   rd_fail;
    logic               chk_active;
    logic               unused_wr_en;

    // The write strobe does not change the parity value itself.
    always_comb unused_wr_en = mem_wr_en;

    // Checking runs only for valid reads with checking enabled.
    always_comb chk_active = mem_rd_en && csr_q.chk;

    pec_par_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_gen (
        .data   (mem_wr_data),
        .invert (csr_q.test),
        .par    (mem_wr_par)
    );

    pec_par_check #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
        .data   (mem_rd_data),
        .par    (mem_rd_par),
        .enable (chk_active),
        .fail   (rd_fail)
    );

    pec_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .RDATA_W(32), .ADDR_OFF(4)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail       (rd_fail),
        .fail_addr  (mem_rd_addr),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .csr_q      (csr_q),
        .err_addr_q (err_addr_q),
        .reg_rdata  (reg_rdata)
    );

    // Interrupt request: pending AND enabled.
    always_comb irq = csr_q.pend && csr_q.ien;
endmodule

// File: rtl/pec_checker.sv
// Module: assertion checker for parity_err_capture, attached with bind.
// Assumes reset is held for at least one edge before any access.
module pec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] mem_wr_data,
    input logic [3:0]  mem_wr_par,
    input logic        mem_rd_en,
    input logic        reg_wr_en,
    input logic [2:0]  reg_addr,
    input logic [7:0]  csr,
    input logic [31:0] err_addr,
    input logic        irq
);
    logic wr_csr;
    always_comb wr_csr = reg_wr_en && (reg_addr == 3'd0);

    // R2 and R1: lane 0 parity follows the test bit.
    a_r2_test_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        csr[5] |-> (^{mem_wr_data[7:0], mem_wr_par[0]}) == 1'b0);
    a_r1_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        !csr[5] |-> (^{mem_wr_data[31:24], mem_wr_par[3]}) == 1'b1);

    // R4: with checking off and nothing pending, nothing becomes pending.
    a_r4_no_check: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr[4] && !csr[7]) |=> !csr[7]);

    // R5: a held record does not change until a status write.
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (csr[7] && !wr_csr) |=> ($stable(csr[3:0]) && $stable(err_addr) && csr[7]));

    // R6: a status write clears the record.
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_csr |=> (!csr[7] && csr[3:0] == 4'h0 && err_addr == 32'h0));

    // R3: pending rises only with at least one lane flag and after a read.
    a_r3_flags_on_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr[7]) |-> (csr[3:0] != 4'h0 && $past(mem_rd_en)));

    // R7: irq falls the cycle after a clearing write.
    a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_csr |=> !irq);
    a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr[7] && csr[6]));
endmodule

bind parity_err_capture pec_checker u_pec_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_wr_data (mem_wr_data),
    .mem_wr_par  (mem_wr_par),
    .mem_rd_en   (mem_rd_en),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .csr         (csr_q),
    .err_addr    (err_addr_q),
    .irq         (irq)
);

// File: tb/tb_parity_err_capture.sv
module tb_parity_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_wr_en = 1'b0;
    logic [31:0] mem_wr_data = '0;
    logic [3:0]  mem_wr_par;
    logic        mem_rd_en = 1'b0;
    logic [31:0] mem_rd_addr = '0;
    logic [31:0] mem_rd_data = '0;
    logic [3:0]  mem_rd_par = '0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [31:0] mem_data [16];
    logic [3:0]  mem_par  [16];

    always #4 clk = ~clk;

    parity_err_capture dut (.*);

    // Vectors: {address, data, parity flip mask}; expected lanes = flip mask.
    localparam int NV = 6;
    localparam logic [67:0] VEC [NV] = '{
        {32'h0000_0004, 32'h1234_5678, 4'h1},
        {32'h0000_0008, 32'hFFFF_FFFF, 4'h2},
        {32'h0000_000C, 32'h0000_0000, 4'h4},
        {32'h0000_0010, 32'h8000_0001, 4'h8},
        {32'h0000_0014, 32'hA5A5_5A5A, 4'h9},
        {32'h0000_0018, 32'h0F0F_F0F0, 4'hF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] odd_par(input logic [31:0] d);
        for (int i = 0; i < 4; i++) odd_par[i] = ~(^d[i*8 +: 8]);
    endfunction

    task automatic csr_wr(input logic [2:0] off, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = off; reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [31:0] v);
        @(negedge clk);
        reg_addr = off;
        #1 v = reg_rdata;
        reg_addr = 3'd0;
    endtask

    task automatic mwrite(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        mem_wr_en = 1'b1; mem_wr_data = d;
        #1;
        mem_data[a[5:2]] = d;
        mem_par[a[5:2]]  = mem_wr_par;
        @(posedge clk);
        @(negedge clk);
        mem_wr_en = 1'b0;
    endtask

    task automatic mread(input logic [31:0] a, input logic [3:0] flip, input logic en);
        @(negedge clk);
        mem_rd_en = en; mem_rd_addr = a;
        mem_rd_data = mem_data[a[5:2]];
        mem_rd_par = mem_par[a[5:2]] ^ flip;
        @(posedge clk);
        @(negedge clk);
        mem_rd_en = 1'b0; mem_rd_par = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin mem_data[i] = '0; mem_par[i] = 4'hF; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8: reset state
        rd(3'd0, v); chk("R8 csr after reset", v, 32'h0);
        rd(3'd4, v); chk("R8 addr after reset", v, 32'h0);
        chk("R8 irq after reset", {31'h0, irq}, 32'h0);

        // Table walk: R1 parity on write, R3 capture, R7 irq
        for (int k = 0; k < NV; k++) begin
            logic [31:0] a, d; logic [3:0] f;
            {a, d, f} = VEC[k];
            csr_wr(3'd0, 32'h50);
            mwrite(a, d);
            chk("R1 write parity", {28'h0, mem_par[a[5:2]]}, {28'h0, odd_par(d)});
            mread(a, f, 1'b1);
            rd(3'd0, v); chk("R3 lane flags", v, {24'h0, 8'hD0 | {4'h0, f}});
            rd(3'd4, v); chk("R3 error address", v, a);
            chk("R7 irq raised", {31'h0, irq}, 32'h1);
        end

        // R7: clearing write drops irq the next cycle
        csr_wr(3'd0, 32'h10);
        chk("R7 irq after clear", {31'h0, irq}, 32'h0);
        rd(3'd0, v); chk("R6 csr after clear", v, 32'h10);

        // R2: test bit inverts stored parity; clean readback fails all lanes
        csr_wr(3'd0, 32'h30);
        mwrite(32'h20, 32'h0102_0304);
        chk("R2 inverted parity", {28'h0, mem_par[8]}, {28'h0, ~odd_par(32'h0102_0304)});
        csr_wr(3'd0, 32'h10);
        mread(32'h20, 4'h0, 1'b1);
        rd(3'd0, v); chk("R2 all lanes fail", v, 32'h9F);
        chk("R7 no irq when disabled", {31'h0, irq}, 32'h0);

        // R4: checking off, nothing recorded
        csr_wr(3'd0, 32'h40);
        mread(32'h04, 4'hF, 1'b1);
        rd(3'd0, v); chk("R4 no record", v, 32'h40);
        rd(3'd4, v); chk("R4 no address", v, 32'h0);

        // R11: bad parity without read strobe
        csr_wr(3'd0, 32'h50);
        mread(32'h08, 4'h3, 1'b0);
        rd(3'd0, v); chk("R11 no strobe no record", v, 32'h50);

        // R5: first error held
        mread(32'h0C, 4'h2, 1'b1);
        mread(32'h10, 4'h8, 1'b1);
        rd(3'd0, v); chk("R5 lanes held", v, 32'hD2);
        rd(3'd4, v); chk("R5 address held", v, 32'h0C);

        // R9: padding offsets read zero, writes to offset 4 ignored
        rd(3'd1, v); chk("R9 offset 1", v, 32'h0);
        rd(3'd3, v); chk("R9 offset 3", v, 32'h0);
        rd(3'd6, v); chk("R9 offset 6", v, 32'h0);
        csr_wr(3'd4, 32'hDEAD_BEEF);
        rd(3'd4, v); chk("R9 addr write ignored", v, 32'h0C);
        csr_wr(3'd2, 32'hFF);
        rd(3'd0, v); chk("R9 padding write ignored", v, 32'hD2);

        // R6: only bits 6..4 load
        csr_wr(3'd0, 32'hFF);
        rd(3'd0, v); chk("R6 only control bits load", v, 32'h70);
        rd(3'd4, v); chk("R6 address cleared", v, 32'h0);

        // R10: status write and failing read in the same cycle
        csr_wr(3'd0, 32'h50);
        @(negedge clk);
        mem_rd_en = 1'b1; mem_rd_addr = 32'h14;
        mem_rd_data = mem_data[5]; mem_rd_par = mem_par[5] ^ 4'h1;
        reg_wr_en = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h50;
        @(posedge clk);
        @(negedge clk);
        mem_rd_en = 1'b0; reg_wr_en = 1'b0;
        rd(3'd0, v); chk("R10 write wins", v, 32'h50);
        chk("R10 no irq", {31'h0, irq}, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule